// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Port

This block is the host-facing parallel port of a display controller. A host processor reaches the controller over an 8-bit data bus with a chip select, a register-select line and two control lines. A static mode input decides how the two control lines are read. In strobe style they are separate active-low read and write strobes. In enable style they are an enable level plus a read/write level. Every access falls into one of four kinds: instruction write, display-data write, status read or display-data read. The register-select line chooses between instruction/status (low) and display data (high).

All host pins are brought into the controller clock domain through a short synchronizer. The register-select line and the data bus travel through the same pipeline, so they stay aligned with the control lines. A write completes when its active phase ends. That is the rising write strobe, the falling enable, or the rising chip select when the enable is held high. The completed write is handed to the core as a one-cycle pulse with an instruction/data flag. Reads drive the data bus, through an output-enable, with either a status byte or a byte supplied by the core. The block holds the display column pointer. The pointer steps by one after every display-data transfer, and the core can load it.

Top module: `host_port`

## Requirements
- R1: After reset, `db_oe`, `wr_valid` and `rd_done` are 0 and `col_addr` is 0.
- R2: While `cs_n` is high, activity on `a0`, `rd_e` and `wr_rw` produces no `wr_valid`, leaves `db_oe` at 0 and leaves `col_addr` unchanged.
- R3: With `bus_mode`=0 (strobe style), a write completes on the rising edge of `wr_rw` while `cs_n` is low. `wr_byte` is the value that was on `db_in` just before that edge.
- R4: With `bus_mode`=1 (enable style), a write is `rd_e` high with `wr_rw` low under `cs_n` low. It completes when `rd_e` falls.
- R5: With `bus_mode`=1 and `rd_e` held high, a write with `wr_rw` low completes on the rising edge of `cs_n`.
- R6: `wr_is_data` equals the `a0` level of the completed write: 1 for display data, 0 for an instruction.
- R7: `db_oe` is 1 only while a read is active and `cs_n` is low. A read is active when `rd_e` is low in strobe style, or when `rd_e` and `wr_rw` are both high in enable style. `db_oe` follows the read with a lag of SYNC_STAGES+1 clock edges at both ends.
- R8: A read with `a0`=0 drives `db_out` = {`busy`, `col_addr`}, with the busy flag in bit 7 and the 7-bit pointer in bits 6..0.
- R9: A read with `a0`=1 drives `db_out` with the `core_rdata` value sampled when the read began. `rd_done` pulses as the read ends.
- R10: `col_addr` increases by one, modulo 128, after each display-data write or display-data read. Instruction writes and status reads leave it unchanged.
- R11: `ptr_load` high for one cycle sets `col_addr` to `ptr_value` on the next edge.
- R12: `wr_valid` and `rd_done` are single-cycle pulses. They rise SYNC_STAGES+1 clock edges after the host ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | 0 = strobe style, 1 = enable style |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Register select: 0 instruction/status, 1 display data |
| rd_e | input | 1 | Read strobe (strobe style) or enable (enable style) |
| wr_rw | input | 1 | Write strobe (strobe style) or read/write level (enable style) |
| db_in | input | DW | Data bus from host |
| db_out | output | DW | Data bus value to host |
| db_oe | output | 1 | Data bus drive enable |
| busy | input | 1 | Core busy flag for the status byte |
| core_rdata | input | DW | Display byte supplied by the core for data reads |
| ptr_load | input | 1 | Load request for the column pointer |
| ptr_value | input | DW-1 | Value loaded into the column pointer |
| col_addr | output | DW-1 | Display column pointer |
| wr_valid | output | 1 | One-cycle pulse for a completed write |
| wr_is_data | output | 1 | 1 = display data, 0 = instruction, valid with wr_valid |
| wr_byte | output | DW | Written byte, valid with wr_valid |
| rd_done | output | 1 | One-cycle pulse at the end of a display-data read |

## Verification
The bench builds the block with DW=8 and SYNC_STAGES=2. With these values the pointer is 7 bits wide, so a load near the top followed by a few data writes carries it through the wrap from 127 to 0. The bench expects every result exactly three edges after the host acts, and it checks the pulses again one cycle later. The bench sweeps both bus styles and both register-select levels over a set of computed data bytes. It also covers the held-enable chip-select write and status reads with the busy flag both low and high.

// File: rtl/host_port_pkg.sv
`timescale 1ns/1ps
// host_port_pkg
// Types and access decoding shared by the host port modules.
// Assumes both bus styles share one chip select and one register-select line.
package host_port_pkg;

    typedef enum logic {
        BUS_STROBE = 1'b0,   // separate active-low read and write strobes
        BUS_ENABLE = 1'b1    // enable level plus read/write level
    } bus_style_e;

    typedef struct packed {
        logic cs_n;    // chip select, active low
        logic ctl_a;   // read strobe or enable
        logic ctl_b;   // write strobe or read/write level
        logic sel;     // register select
    } pin_ctl_t;

    // Reset image of the control pins: deselected, everything else low
    localparam logic [3:0] PIN_CTL_IDLE = 4'b1000;

    // Returns {read_active, write_active} for the given pin levels
    function automatic logic [1:0] access_level(bus_style_e style, pin_ctl_t p);
        logic rd_lvl;
        logic wr_lvl;
        if (style == BUS_STROBE) begin
            rd_lvl = !p.cs_n && !p.ctl_a;
            wr_lvl = !p.cs_n && !p.ctl_b;
        end else begin
            rd_lvl = !p.cs_n && p.ctl_a && p.ctl_b;
            wr_lvl = !p.cs_n && p.ctl_a && !p.ctl_b;
        end
        return {rd_lvl, wr_lvl};
    endfunction

endpackage

// File: rtl/host_port_sync.sv
`timescale 1ns/1ps
// host_port_sync
// Chain of STAGES flops that brings host pins into the clock domain.
// Assumes STAGES >= 1; every bit is delayed the same, so grouped pins stay aligned.
module host_port_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later flops pass the value along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/host_port_decode.sv
`timescale 1ns/1ps
// host_port_decode
// Turns synchronized pin levels into access events.
// A write completes on the cycle its active level drops, using the select line
// and data from the last active cycle. Read start/end are flagged likewise.
// Assumes the host holds select and data stable across the closing edge.
module host_port_decode
    import host_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_style_e    style,
    input  pin_ctl_t      ctl,
    input  logic [DW-1:0] data,
    output logic          wr_evt,
    output logic          wr_evt_sel,
    output logic          wr_valid,
    output logic          wr_is_data,
    output logic [DW-1:0] wr_byte,
    output logic          rd_now,
    output logic          rd_start,
    output logic          rd_end
);

    logic [1:0]    lvl;
    logic          wr_now;
    logic          rd_q;
    logic          wr_q;
    logic          sel_q;
    logic [DW-1:0] data_q;

    assign lvl    = access_level(style, ctl);
    assign rd_now = lvl[1];
    assign wr_now = lvl[0];

    // Previous-cycle levels and bus contents for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            sel_q  <= 1'b0;
            data_q <= '0;
        end else begin
            rd_q   <= rd_now;
            wr_q   <= wr_now;
            sel_q  <= ctl.sel;
            data_q <= data;
        end
    end

    assign wr_evt     = wr_q && !wr_now;
    assign wr_evt_sel = sel_q;
    assign rd_start   = rd_now && !rd_q;
    assign rd_end     = rd_q && !rd_now;

    // Register the completed write towards the core as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_is_data <= 1'b0;
            wr_byte    <= '0;
        end else begin
            wr_valid <= wr_evt;
            if (wr_evt) begin
                wr_is_data <= sel_q;
                wr_byte    <= data_q;
            end
        end
    end

endmodule

// File: rtl/host_port_readback.sv
`timescale 1ns/1ps
// host_port_readback
// Chooses and holds the byte returned on a read and drives the bus enable.
// The byte is frozen when the read starts: status {busy, pointer} for select
// low, core data for select high. Flags the end of a data read.
module host_port_readback #(
    parameter int DW = 8,
    localparam int AW = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_now,
    input  logic          rd_start,
    input  logic          rd_end,
    input  logic          start_sel,
    input  logic          busy,
    input  logic [AW-1:0] col_addr,
    input  logic [DW-1:0] core_rdata,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic          data_rd_end,
    output logic          rd_done
);

    logic kind_data_q;

    // Freeze the read byte at read start and follow the read level with the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_out      <= '0;
            db_oe       <= 1'b0;
            kind_data_q <= 1'b0;
        end else begin
            db_oe <= rd_now;
            if (rd_start) begin
                kind_data_q <= start_sel;
                db_out      <= start_sel ? core_rdata : {busy, col_addr};
            end
        end
    end

    assign data_rd_end = rd_end && kind_data_q;

    // Tell the core a display-data read has finished
    always_ff @(posedge clk) begin
        if (!rst_n) rd_done <= 1'b0;
        else        rd_done <= data_rd_end;
    end

endmodule

// File: rtl/host_port_colptr.sv
`timescale 1ns/1ps
// host_port_colptr
// Display column pointer: loadable by the core, steps once per data transfer.
// A load takes priority over any step in the same cycle; the count wraps.
module host_port_colptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_wr,
    input  logic          step_rd,
    output logic [AW-1:0] ptr
);

    // Load, step or hold the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_val;
        else            ptr <= ptr + AW'(step_wr) + AW'(step_rd);
    end

endmodule

// File: rtl/host_port.sv
`timescale 1ns/1ps
// host_port
// Host-side parallel port serving strobe-style and enable-style buses.
// Assumes bus_mode is static and host pins are asynchronous to clk; the host
// holds select and data for at least one clk beyond each closing edge.
module host_port
    import host_port_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          cs_n,
    input  logic          a0,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    input  logic          busy,
    input  logic [DW-1:0] core_rdata,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    output logic [AW-1:0] col_addr,
    output logic          wr_valid,
    output logic          wr_is_data,
    output logic [DW-1:0] wr_byte,
    output logic          rd_done
);

    bus_style_e    style;
    pin_ctl_t      ctl_raw;
    logic [3:0]    ctl_sync;
    pin_ctl_t      ctl_s;
    logic [DW-1:0] data_s;
    logic          wr_evt;
    logic          wr_evt_sel;
    logic          rd_now;
    logic          rd_start;
    logic          rd_end;
    logic          data_rd_end;

    assign style   = bus_style_e'(bus_mode);
    assign ctl_raw = '{cs_n: cs_n, ctl_a: rd_e, ctl_b: wr_rw, sel: a0};
    assign ctl_s   = pin_ctl_t'(ctl_sync);

    host_port_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_CTL_IDLE)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_sync)
    );

    host_port_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(db_in), .q(data_s)
    );

    host_port_decode #(.DW(DW)) u_decode (
        .clk(clk), .rst_n(rst_n), .style(style), .ctl(ctl_s), .data(data_s),
        .wr_evt(wr_evt), .wr_evt_sel(wr_evt_sel), .wr_valid(wr_valid),
        .wr_is_data(wr_is_data), .wr_byte(wr_byte),
        .rd_now(rd_now), .rd_start(rd_start), .rd_end(rd_end)
    );

    host_port_readback #(.DW(DW)) u_readback (
        .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .rd_start(rd_start),
        .rd_end(rd_end), .start_sel(ctl_s.sel), .busy(busy), .col_addr(col_addr),
        .core_rdata(core_rdata), .db_out(db_out), .db_oe(db_oe),
        .data_rd_end(data_rd_end), .rd_done(rd_done)
    );

    host_port_colptr #(.AW(AW)) u_colptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_value),
        .step_wr(wr_evt && wr_evt_sel), .step_rd(data_rd_end), .ptr(col_addr)
    );

endmodule

// File: rtl/host_port_chk.sv
`timescale 1ns/1ps
// host_port_chk
// Port-level temporal checks for host_port, attached by bind.
// Assumes SYNC_STAGES + 2 fits the 4-bit quiet counter.
module host_port_chk #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = DW - 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          db_oe,
    input logic          wr_valid,
    input logic          wr_is_data,
    input logic          rd_done,
    input logic          ptr_load,
    input logic [AW-1:0] ptr_value,
    input logic [AW-1:0] col_addr
);

    logic [3:0] quiet_cnt;

    // Count cycles with chip select high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)             quiet_cnt <= '0;
        else if (!cs_n)         quiet_cnt <= '0;
        else if (quiet_cnt != 4'hF) quiet_cnt <= quiet_cnt + 4'd1;
    end

    // R2: once the pipeline has drained under a high chip select, nothing happens
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(quiet_cnt) > SYNC_STAGES + 1) |-> (!db_oe && !wr_valid && !rd_done));

    // R10: a data write moves the pointer by exactly one unless a load intervened
    a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_is_data && !$past(ptr_load)) |->
            (col_addr == $past(col_addr) + AW'(1)));

    // R11: load value appears on the next edge
    a_r11_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (col_addr == $past(ptr_value)));

    // R12: write pulse lasts one cycle
    a_r12_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R12: read-done pulse lasts one cycle
    a_r12_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

endmodule

bind host_port host_port_chk #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .db_oe(db_oe), .wr_valid(wr_valid),
    .wr_is_data(wr_is_data), .rd_done(rd_done), .ptr_load(ptr_load),
    .ptr_value(ptr_value), .col_addr(col_addr)
);

// File: tb/host_port_bench.sv
`timescale 1ns/1ps
// host_port_bench
// Sweeps both bus styles, both select levels and computed data bytes.
module host_port_bench;

    localparam int DW = 8;
    localparam int SS = 2;
    localparam int AW = DW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_mode = 1'b0;
    logic          cs_n = 1'b1;
    logic          a0 = 1'b0;
    logic          rd_e = 1'b1;
    logic          wr_rw = 1'b1;
    logic [DW-1:0] db_in = '0;
    logic [DW-1:0] db_out;
    logic          db_oe;
    logic          busy = 1'b0;
    logic [DW-1:0] core_rdata = '0;
    logic          ptr_load = 1'b0;
    logic [AW-1:0] ptr_value = '0;
    logic [AW-1:0] col_addr;
    logic          wr_valid;
    logic          wr_is_data;
    logic [DW-1:0] wr_byte;
    logic          rd_done;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_pulses = 0;
    int oe_cycles = 0;
    logic [AW-1:0] exp_ptr = '0;

    always #5 clk = ~clk;

    host_port #(.DW(DW), .SYNC_STAGES(SS)) u_host_port (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .a0(a0),
        .rd_e(rd_e), .wr_rw(wr_rw), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
        .busy(busy), .core_rdata(core_rdata), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .col_addr(col_addr), .wr_valid(wr_valid),
        .wr_is_data(wr_is_data), .wr_byte(wr_byte), .rd_done(rd_done)
    );

    // Observe pulses and bus enable away from the active edge
    always @(negedge clk) begin
        if (wr_valid) wr_pulses++;
        if (db_oe)    oe_cycles++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_idle();
        cs_n  = 1'b1;
        rd_e  = (bus_mode == 1'b0);
        wr_rw = 1'b1;
    endtask

    task automatic do_write(input logic sel, input logic [DW-1:0] d);
        string tag;
        tag = bus_mode ? "R4" : "R3";
        @(negedge clk); cs_n = 1'b0; a0 = sel; db_in = d;
        if (bus_mode) wr_rw = 1'b0;
        idle(3);
        if (bus_mode) rd_e = 1'b1; else wr_rw = 1'b0;
        idle(4);
        if (bus_mode) rd_e = 1'b0; else wr_rw = 1'b1;
        repeat (SS + 1) @(posedge clk);
        @(negedge clk);
        if (sel) exp_ptr = exp_ptr + AW'(1);
        check(wr_valid === 1'b1, "R12 wr_valid latency", int'(wr_valid), 1);
        check(wr_byte === d, tag, int'(wr_byte), int'(d));
        check(wr_is_data === sel, "R6", int'(wr_is_data), int'(sel));
        check(col_addr === exp_ptr, "R10 write step", int'(col_addr), int'(exp_ptr));
        @(negedge clk);
        check(wr_valid === 1'b0, "R12 wr pulse width", int'(wr_valid), 0);
        settle_idle();
        idle(3);
    endtask

    // Enable held high; the chip select closes the write
    task automatic do_write_cs(input logic sel, input logic [DW-1:0] d);
        @(negedge clk); rd_e = 1'b1; wr_rw = 1'b0; a0 = sel; db_in = d;
        idle(3);
        cs_n = 1'b0;
        idle(4);
        cs_n = 1'b1;
        repeat (SS + 1) @(posedge clk);
        @(negedge clk);
        if (sel) exp_ptr = exp_ptr + AW'(1);
        check(wr_valid === 1'b1, "R5 cs-closed write", int'(wr_valid), 1);
        check(wr_byte === d, "R5 byte", int'(wr_byte), int'(d));
        check(wr_is_data === sel, "R6 cs write", int'(wr_is_data), int'(sel));
        check(col_addr === exp_ptr, "R10 cs write step", int'(col_addr), int'(exp_ptr));
        settle_idle();
        idle(3);
    endtask

    task automatic do_read(input logic sel, input logic [DW-1:0] exp);
        @(negedge clk); cs_n = 1'b0; a0 = sel;
        if (bus_mode) wr_rw = 1'b1;
        idle(4);
        check(db_oe === 1'b0, "R7 no drive without read", int'(db_oe), 0);
        if (bus_mode) rd_e = 1'b1; else rd_e = 1'b0;
        repeat (SS + 1) @(posedge clk);
        @(negedge clk);
        check(db_oe === 1'b1, "R7 drive during read", int'(db_oe), 1);
        check(db_out === exp, sel ? "R9 data read" : "R8 status read", int'(db_out), int'(exp));
        idle(2);
        if (bus_mode) rd_e = 1'b0; else rd_e = 1'b1;
        repeat (SS + 1) @(posedge clk);
        @(negedge clk);
        if (sel) exp_ptr = exp_ptr + AW'(1);
        check(db_oe === 1'b0, "R7 release after read", int'(db_oe), 0);
        check(rd_done === sel, "R9 rd_done", int'(rd_done), int'(sel));
        check(col_addr === exp_ptr, "R10 read step", int'(col_addr), int'(exp_ptr));
        settle_idle();
        idle(3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(db_oe === 1'b0, "R1 db_oe", int'(db_oe), 0);
        check(wr_valid === 1'b0, "R1 wr_valid", int'(wr_valid), 0);
        check(rd_done === 1'b0, "R1 rd_done", int'(rd_done), 0);
        check(col_addr === '0, "R1 col_addr", int'(col_addr), 0);

        // R3/R4/R6/R10: write sweep over styles, select levels and bytes
        for (int m = 0; m < 2; m++) begin
            bus_mode = m[0];
            settle_idle();
            idle(3);
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 8; k++) begin
                    do_write(s[0], DW'((k * 37 + m * 91 + s * 13 + 5) & 8'hFF));
                end
            end
        end

        // R5: enable held high, chip select closes the write
        bus_mode = 1'b1;
        settle_idle();
        for (int k = 0; k < 6; k++) begin
            do_write_cs(k[0], DW'((k * 29 + 3) & 8'hFF));
        end

        // R7/R8/R9/R10: reads in both styles
        for (int m = 0; m < 2; m++) begin
            bus_mode = m[0];
            settle_idle();
            idle(3);
            for (int k = 0; k < 4; k++) begin
                busy = k[0];
                do_read(1'b0, {busy, exp_ptr});
                core_rdata = DW'((k * 53 + m * 17 + 9) & 8'hFF);
                do_read(1'b1, core_rdata);
            end
        end
        busy = 1'b0;

        // R2: deselected activity is ignored
        for (int m = 0; m < 2; m++) begin
            bus_mode = m[0];
            settle_idle();
            idle(4);
            wr_pulses = 0;
            oe_cycles = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk); rd_e = ~rd_e; a0 = k[1];
                idle(3);
                wr_rw = ~wr_rw;
                idle(3);
            end
            settle_idle();
            idle(6);
            check(wr_pulses == 0, "R2 no write while deselected", wr_pulses, 0);
            check(oe_cycles == 0, "R2 no drive while deselected", oe_cycles, 0);
            check(col_addr === exp_ptr, "R2 pointer unchanged", int'(col_addr), int'(exp_ptr));
        end

        // R11 then R10 wrap: load near the top and step through 127 -> 0
        @(negedge clk); ptr_load = 1'b1; ptr_value = AW'(126);
        @(negedge clk); ptr_load = 1'b0;
        exp_ptr = AW'(126);
        check(col_addr === AW'(126), "R11 pointer load", int'(col_addr), 126);
        bus_mode = 1'b0;
        settle_idle();
        idle(3);
        for (int k = 0; k < 3; k++) begin
            do_write(1'b1, DW'(k + 200));
        end
        check(col_addr === AW'(1), "R10 wrap", int'(col_addr), 1);
        do_write(1'b0, 8'h3C);
        check(col_addr === AW'(1), "R10 instruction holds pointer", int'(col_addr), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule